// File: doc/BRIEF.md
# Predicated Reverse Left-Shift Vector Unit

This block is one stage of a vector datapath. It shifts each lane of a vector left, with the operand roles swapped: the data to shift comes from the second source vector, and the shift count comes from the matching lane of the first source. The first source is also the destination. The lane width is selected per operation by a 2-bit size code, giving 8-, 16-, 32- or 64-bit lanes across a vector of `VLEN` bits (default 128).

A byte-granular predicate decides which lanes are written. An inactive lane passes its first-source value through unchanged, which is merge predication. A shift count is read as an unsigned number over the whole lane. It is never reduced modulo the lane width, so a count equal to or larger than the lane width clears the lane.

An operation is presented with `op_valid`. Its result appears one clock later with `res_valid`. The result is held until the next operation, and the latency never depends on operand values.

Top module: `vec_rshl_pred`

## Requirements
- R1: The size code selects the lane width as 8 << code: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. Lane e occupies bits [e*W +: W].
- R2: In an active lane, the result is the `src_vec` lane shifted left by the unsigned count in the same lane of `dn_vec`. Vacated low bits are filled with zeros and bits shifted past the top are lost.
- R3: A count of the lane width or more, judged on every bit of the count lane including the maximum all-ones value, gives an all-zero lane.
- R4: An inactive lane returns its `dn_vec` value unchanged.
- R5: Lane e is active exactly when `pred` bit e*(W/8) is 1. The other predicate bits have no effect on the result.
- R6: `res_valid` is high in the cycle after a cycle with `op_valid` high, and low otherwise. `res_vec` carries that operation's result in the same cycle, whatever the operand values.
- R7: While `op_valid` is low, `res_vec` keeps its last value regardless of the other inputs.
- R8: After reset, `res_valid` is 0 and `res_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Captures an operation this cycle |
| size_code | input | 2 | Lane width select |
| dn_vec | input | VLEN | Shift counts and merge values (first source/destination) |
| src_vec | input | VLEN | Data to be shifted (second source) |
| pred | input | VLEN/8 | One predicate bit per byte |
| res_valid | output | 1 | Result is valid |
| res_vec | output | VLEN | Result vector that replaces the destination |

## Verification
Merging and saturation can occur in the same operation and in neighbouring lanes: one lane may be inactive and must return its count value, while the lane beside it is active with an oversized count and must clear. Random operations over all four sizes mix out-of-range counts with sparse predicates. Directed cases place the counts 0, W-1, W and all-ones under all-one, all-zero and non-governing-bit-only masks. Each result is compared, as a whole vector, with a bench reference model taken one cycle after the operation is issued.

// File: rtl/vec_rshl_pred.sv
module vec_rshl_pred #(
  parameter int VLEN = 128,
  localparam int PW = VLEN / 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [1:0]      size_code,
  input  logic [VLEN-1:0] dn_vec,
  input  logic [VLEN-1:0] src_vec,
  input  logic [PW-1:0]   pred,
  output logic            res_valid,
  output logic [VLEN-1:0] res_vec
);

  logic [VLEN-1:0] by_size [4];
  logic [VLEN-1:0] nxt;

  for (genvar s = 0; s < 4; s++) begin : g_size
    localparam int EW = 8 << s;
    localparam int NL = VLEN / EW;
    localparam int SW = $clog2(EW);
    localparam logic [EW-1:0] EWV = EW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      logic [EW-1:0] cnt, dat, shl;
      logic act, ovf;
      assign cnt = dn_vec[l*EW +: EW];
      assign dat = src_vec[l*EW +: EW];
      assign act = pred[l*(EW/8)];
      assign ovf = cnt >= EWV;
      assign shl = dat << cnt[SW-1:0];
      assign by_size[s][l*EW +: EW] = !act ? cnt : (ovf ? '0 : shl);
    end
  end

  assign nxt = by_size[size_code];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      res_valid <= op_valid;
      if (op_valid) res_vec <= nxt;
    end
  end

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);
  p_no_spurious_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid);
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(res_vec));
  p_byte_saturate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && size_code == 2'b00 && pred[0] && dn_vec[7:0] >= 8'd8)
    |=> res_vec[7:0] == 8'h00);
  p_byte_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && size_code == 2'b00 && !pred[0])
    |=> res_vec[7:0] == $past(dn_vec[7:0]));
  p_dword_zero_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && size_code == 2'b11 && pred[0] && dn_vec[63:0] == 64'd0)
    |=> res_vec[63:0] == $past(src_vec[63:0]));
  p_dword_gov_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && size_code == 2'b11 && !pred[0])
    |=> res_vec[63:0] == $past(dn_vec[63:0]));

endmodule

// File: tb/tb_vec_rshl_pred.sv
module tb_vec_rshl_pred;
  localparam int VLEN = 128;
  localparam int PW = VLEN / 8;

  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [1:0] size_code = 0;
  logic [VLEN-1:0] dn_vec = '0, src_vec = '0;
  logic [PW-1:0] pred = '0;
  logic res_valid;
  logic [VLEN-1:0] res_vec;

  int checks = 0, fails = 0;
  bit done = 0;

  vec_rshl_pred #(.VLEN(VLEN)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .size_code(size_code),
    .dn_vec(dn_vec), .src_vec(src_vec), .pred(pred),
    .res_valid(res_valid), .res_vec(res_vec));

  always #10 clk = ~clk;

  function automatic logic [VLEN-1:0] ref_calc(logic [VLEN-1:0] dn, logic [VLEN-1:0] sr,
                                               logic [PW-1:0] p, logic [1:0] sz);
    int ew = 8 << sz;
    logic [VLEN-1:0] r = '0;
    for (int l = 0; l < VLEN / ew; l++) begin
      logic [63:0] c = '0, d = '0, o;
      for (int b = 0; b < ew; b++) begin c[b] = dn[l*ew+b]; d[b] = sr[l*ew+b]; end
      if (!p[l*(ew/8)]) o = c;
      else if (c >= 64'(ew)) o = '0;
      else o = d << c;
      for (int b = 0; b < ew; b++) r[l*ew+b] = o[b];
    end
    return r;
  endfunction

  task automatic check(string req, logic [VLEN-1:0] act, logic [VLEN-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(string req, logic [1:0] sz, logic [VLEN-1:0] dn,
                        logic [VLEN-1:0] sr, logic [PW-1:0] p);
    logic [VLEN-1:0] exp;
    exp = ref_calc(dn, sr, p, sz);
    @(negedge clk);
    op_valid = 1; size_code = sz; dn_vec = dn; src_vec = sr; pred = p;
    @(negedge clk);
    op_valid = 0;
    check({req, " (R6 valid)"}, {{(VLEN-1){1'b0}}, res_valid}, {{(VLEN-1){1'b0}}, 1'b1});
    check(req, res_vec, exp);
  endtask

  function automatic logic [VLEN-1:0] fill_counts(logic [1:0] sz, logic [63:0] v);
    int ew = 8 << sz;
    logic [VLEN-1:0] r = '0;
    for (int l = 0; l < VLEN / ew; l++)
      for (int b = 0; b < ew; b++) r[l*ew+b] = v[b];
    return r;
  endfunction

  function automatic logic [VLEN-1:0] rnd_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [VLEN-1:0] rnd_counts(logic [1:0] sz);
    int ew = 8 << sz;
    logic [VLEN-1:0] r = rnd_vec();
    for (int l = 0; l < VLEN / ew; l++) begin
      logic [63:0] v = 64'($urandom % (ew + 3));
      if (($urandom % 4) != 0)
        for (int b = 0; b < ew; b++) r[l*ew+b] = v[b];
    end
    return r;
  endfunction

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
    end
  end

  initial begin
    logic [VLEN-1:0] held;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R8 reset state
    check("R8 res_valid", {{(VLEN-1){1'b0}}, res_valid}, '0);
    check("R8 res_vec", res_vec, '0);
    rst_n = 1;
    @(negedge clk);
    check("R6 idle valid low", {{(VLEN-1){1'b0}}, res_valid}, '0);

    for (int s = 0; s < 4; s++) begin
      int ew = 8 << s;
      logic [VLEN-1:0] sr = rnd_vec();
      run_op("R1 R2 count zero", 2'(s), '0, sr, '1);
      run_op("R2 count width-1", 2'(s), fill_counts(2'(s), 64'(ew - 1)), sr, '1);
      run_op("R3 count width", 2'(s), fill_counts(2'(s), 64'(ew)), sr, '1);
      run_op("R3 count all-ones", 2'(s), '1, sr, '1);
      run_op("R4 all-zero mask", 2'(s), rnd_counts(2'(s)), sr, '0);
    end
    // R5: only non-governing predicate bits set for 64-bit lanes
    run_op("R5 non-governing bits", 2'b11, fill_counts(2'b11, 64'd3), rnd_vec(), 16'h7E7E);
    run_op("R5 governing bits only", 2'b11, fill_counts(2'b11, 64'd5), rnd_vec(), 16'h0101);
    run_op("R5 halfword odd bits", 2'b01, fill_counts(2'b01, 64'd1), rnd_vec(), 16'hAAAA);
    // R3 with R4 neighbours: oversized count in active lane next to inactive lane
    run_op("R3 R4 mixed lanes", 2'b00, {16{8'hC8}}, rnd_vec(), 16'h5555);

    for (int i = 0; i < 400; i++) begin
      logic [1:0] sz = 2'($urandom % 4);
      logic [PW-1:0] p = PW'($urandom);
      if (i % 17 == 0) p = '0;
      if (i % 13 == 0) p = '1;
      run_op("R1 R2 R3 R4 R5 random", sz, rnd_counts(sz), rnd_vec(), p);
    end

    // R7 hold while idle
    held = res_vec;
    @(negedge clk);
    dn_vec = rnd_vec(); src_vec = rnd_vec(); pred = '1; size_code = 2'b10;
    repeat (3) @(negedge clk);
    check("R7 hold", res_vec, held);
    check("R6 no valid when idle", {{(VLEN-1){1'b0}}, res_valid}, '0);

    done = 1;
    finish_up();
  end
endmodule